// File: doc/BRIEF.md
# Sectored Set-Associative Cache Tag Controller

This block looks up byte addresses in a set-associative cache whose 64-byte lines are split into four 16-byte sectors. Each sector has its own valid bit, so a line can be partly present. A request carries an address and a sector mask. It completes once the tag matches and every requested sector is valid. Any requested sector that is missing is fetched alone from the next memory level, one 16-byte fill per sector.

The controller takes one request at a time. When the tag misses, it picks the least recently used way of the set, drops every sector of that line, installs the new tag and fetches only the requested sectors. It does not fetch the whole line. Fill requests leave on a valid/ready channel. Fill responses come back tagged with set, way and sector index, in any order, and write the sector data into a simple storage array.

Top module: `sector_tag_cache`

## Requirements
- R1: After reset, req_ready is 1 and both resp_valid and fill_req_valid are 0.
- R2: resp_valid is raised for one cycle only when the tag matches and all requested sectors are valid. Sector i occupies resp_data bits [32*i+31:32*i]. Lanes of unrequested sectors read zero.
- R3: For each request, fills are issued only for requested sectors that are not valid. Each such sector gets exactly one fill, lowest index first. fill_req_addr is the sector's byte address: tag, set and sector index, then four zero bits.
- R4: A request whose mask covers all four sectors of an absent line issues four fills. Repeating it then issues none.
- R5: Successive single-sector requests to different sectors of the same line each issue one fill. Sectors fetched earlier stay valid.
- R6: On a tag miss, all sector valid bits of the chosen line are cleared. A later request for the evicted tag refetches every requested sector.
- R7: The victim is the least recently completed way of the set. Completing a request, whether by hit or after fills, makes its way the most recently used. Never-used ways are chosen before used ones.
- R8: req_ready stays 0 from acceptance until the cycle after resp_valid. A request to a sector whose fill is pending is held and later completes with no further fill.
- R9: A fill response writes fill_rsp_data into the addressed set, way and sector and marks that sector valid. Responses returned in reverse issue order give correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_addr | input | 16 | Byte address; bits [7:6] set, [15:8] tag |
| req_mask | input | 4 | Requested sectors, nonzero |
| resp_valid | output | 1 | Request complete |
| resp_data | output | 128 | Requested sector data, four 32-bit lanes |
| fill_req_valid | output | 1 | Sector fill request |
| fill_req_ready | input | 1 | Next level accepts the fill |
| fill_req_addr | output | 16 | Byte address of the sector |
| fill_req_set | output | 2 | Set being filled |
| fill_req_way | output | 1 | Way being filled |
| fill_req_sector | output | 2 | Sector index being filled |
| fill_rsp_valid | input | 1 | Fill data returned |
| fill_rsp_set | input | 2 | Set of returned sector |
| fill_rsp_way | input | 1 | Way of returned sector |
| fill_rsp_sector | input | 2 | Index of returned sector |
| fill_rsp_data | input | 32 | Returned sector data |

## Verification
A corrupted valid bit or tag shows up at once at the fill port as an extra or missing fill for the very next request to that line. A corrupted recency order surfaces only on the next conflict in that set, as a refetch of a line that should have survived. Wrongly routed fill data shows up in the same request's response lanes. The bench keeps its own recency-ordered model of each set and compares the fill count, the fill addresses and the response data for every request over a long pseudo-random sweep.

// File: rtl/sector_tag_cache.sv
`timescale 1ns/1ps
module sector_tag_cache #(
  parameter int ADDR_W    = 16,
  parameter int SETS      = 4,
  parameter int WAYS      = 2,
  parameter int SECTORS   = 4,
  parameter int SEC_BYTES = 16,
  parameter int DW        = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [SECTORS-1:0]         req_mask,
  output logic                       resp_valid,
  output logic [SECTORS*DW-1:0]      resp_data,
  output logic                       fill_req_valid,
  input  logic                       fill_req_ready,
  output logic [ADDR_W-1:0]          fill_req_addr,
  output logic [$clog2(SETS)-1:0]    fill_req_set,
  output logic [$clog2(WAYS)-1:0]    fill_req_way,
  output logic [$clog2(SECTORS)-1:0] fill_req_sector,
  input  logic                       fill_rsp_valid,
  input  logic [$clog2(SETS)-1:0]    fill_rsp_set,
  input  logic [$clog2(WAYS)-1:0]    fill_rsp_way,
  input  logic [$clog2(SECTORS)-1:0] fill_rsp_sector,
  input  logic [DW-1:0]              fill_rsp_data
);
  localparam int SOFF_W = $clog2(SEC_BYTES);
  localparam int SEC_W  = $clog2(SECTORS);
  localparam int OFF_W  = SOFF_W + SEC_W;
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;

  typedef enum logic [1:0] {IDLE, FILL, RESP} st_t;
  st_t st_q;

  logic [TAG_W-1:0]   tag_q [SETS][WAYS];
  logic [SECTORS-1:0] vld_q [SETS][WAYS];
  logic [WAY_W-1:0]   age_q [SETS][WAYS];
  logic [DW-1:0]      dat_q [SETS][WAYS][SECTORS];

  logic [SET_W-1:0]   cur_set;
  logic [WAY_W-1:0]   cur_way;
  logic [SECTORS-1:0] cur_mask, iss_q, wait_q;

  wire [SET_W-1:0] req_set = req_addr[OFF_W +: SET_W];
  wire [TAG_W-1:0] req_tag = req_addr[ADDR_W-1 -: TAG_W];

  logic             hit;
  logic [WAY_W-1:0] hit_way, vic_way;
  always_comb begin
    hit = 1'b0; hit_way = '0; vic_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (tag_q[req_set][w] == req_tag && |vld_q[req_set][w]) begin
        hit = 1'b1; hit_way = WAY_W'(w);
      end
      if (age_q[req_set][w] == WAY_W'(WAYS-1)) vic_way = WAY_W'(w);
    end
  end

  wire [WAY_W-1:0]   acc_way  = hit ? hit_way : vic_way;
  wire [SECTORS-1:0] acc_miss = req_mask & (hit ? ~vld_q[req_set][hit_way] : '1);
  wire               accept   = req_valid && req_ready;

  logic [SEC_W-1:0] fill_sec;
  always_comb begin
    fill_sec = '0;
    for (int i = SECTORS-1; i >= 0; i--) if (iss_q[i]) fill_sec = SEC_W'(i);
  end

  assign req_ready       = (st_q == IDLE);
  assign resp_valid      = (st_q == RESP);
  assign fill_req_valid  = (st_q == FILL) && |iss_q;
  assign fill_req_set    = cur_set;
  assign fill_req_way    = cur_way;
  assign fill_req_sector = fill_sec;
  assign fill_req_addr   = {tag_q[cur_set][cur_way], cur_set, fill_sec, {SOFF_W{1'b0}}};

  always_comb begin
    resp_data = '0;
    for (int i = 0; i < SECTORS; i++)
      if (cur_mask[i]) resp_data[i*DW +: DW] = dat_q[cur_set][cur_way][i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= IDLE;
      cur_set <= '0; cur_way <= '0; cur_mask <= '0; iss_q <= '0; wait_q <= '0;
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w] <= '0; vld_q[s][w] <= '0; age_q[s][w] <= WAY_W'(w);
        end
    end else begin
      case (st_q)
        IDLE: if (accept) begin
          cur_set <= req_set; cur_way <= acc_way; cur_mask <= req_mask;
          iss_q <= acc_miss; wait_q <= acc_miss;
          if (!hit) begin
            tag_q[req_set][acc_way] <= req_tag;
            vld_q[req_set][acc_way] <= '0;
          end
          st_q <= (|acc_miss) ? FILL : RESP;
        end
        FILL: begin
          if (fill_req_valid && fill_req_ready) iss_q[fill_sec] <= 1'b0;
          if (fill_rsp_valid) begin
            vld_q[fill_rsp_set][fill_rsp_way][fill_rsp_sector] <= 1'b1;
            wait_q[fill_rsp_sector] <= 1'b0;
          end
          if (wait_q == '0 && iss_q == '0) st_q <= RESP;
        end
        RESP: begin
          for (int w = 0; w < WAYS; w++)
            if (WAY_W'(w) == cur_way) age_q[cur_set][w] <= '0;
            else if (age_q[cur_set][w] < age_q[cur_set][cur_way])
              age_q[cur_set][w] <= age_q[cur_set][w] + 1'b1;
          st_q <= IDLE;
        end
        default: st_q <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (st_q == FILL && fill_rsp_valid)
      dat_q[fill_rsp_set][fill_rsp_way][fill_rsp_sector] <= fill_rsp_data;

  // R3: a fill never targets a sector that is already present
  assert_fill_absent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |-> !vld_q[cur_set][cur_way][fill_req_sector]);

  // R3: an accepted fill is not issued again for the same sector
  assert_single_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && fill_req_ready) |=>
      !(fill_req_valid && fill_req_sector == $past(fill_req_sector)));

  // R2: completion only with every requested sector valid
  assert_resp_complete_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ((vld_q[cur_set][cur_way] & cur_mask) == cur_mask));

  // R8: no new request is taken between acceptance and completion
  assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready);

  function automatic int age_sum(input int s);
    int t = 0;
    for (int w = 0; w < WAYS; w++) t += int'(age_q[s][w]);
    return t;
  endfunction

  for (genvar s = 0; s < SETS; s++) begin : g_lru_chk
    // R7: recency ages of a set stay a permutation
    assert_lru_perm_R7: assert property (@(posedge clk) disable iff (!rst_n)
      age_sum(s) == WAYS*(WAYS-1)/2);
  end
endmodule

// File: tb/sector_tag_cache_tb.sv
`timescale 1ns/1ps
module sector_tag_cache_tb_top;
  localparam int WAYS = 2;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         req_valid = 1'b0, req_ready;
  logic [15:0]  req_addr = '0;
  logic [3:0]   req_mask = '0;
  logic         resp_valid;
  logic [127:0] resp_data;
  logic         fill_req_valid, fill_req_ready = 1'b1;
  logic [15:0]  fill_req_addr;
  logic [1:0]   fill_req_set, fill_req_sector;
  logic         fill_req_way;
  logic         fill_rsp_valid = 1'b0;
  logic [1:0]   fill_rsp_set = '0, fill_rsp_sector = '0;
  logic         fill_rsp_way = 1'b0;
  logic [31:0]  fill_rsp_data = '0;

  sector_tag_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_mask(req_mask),
    .resp_valid(resp_valid), .resp_data(resp_data),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
    .fill_req_addr(fill_req_addr), .fill_req_set(fill_req_set),
    .fill_req_way(fill_req_way), .fill_req_sector(fill_req_sector),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_set(fill_rsp_set),
    .fill_rsp_way(fill_rsp_way), .fill_rsp_sector(fill_rsp_sector),
    .fill_rsp_data(fill_rsp_data)
  );

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] memf(input logic [15:0] a);
    return {a, a ^ 16'hA5C3};
  endfunction

  logic [7:0] mtag  [4][WAYS];
  logic [3:0] mmask [4][WAYS];
  int         mcnt  [4];

  task automatic do_req(input logic [15:0] addr, input logic [3:0] mask,
                        input bit keep, input string rq);
    logic [1:0]   set = addr[7:6];
    logic [7:0]   tag = addr[15:8];
    int           k = -1, n = 0, nexp = 0, nc;
    logic [3:0]   miss;
    logic [15:0]  efa [4];
    logic [15:0]  fa [8];
    logic [1:0]   fs [8], fsec [8];
    logic         fw [8];
    logic [127:0] edata = '0;
    bit           sent = 0, busy_ok = 1;
    for (int j = 0; j < mcnt[set]; j++) if (mtag[set][j] == tag) k = j;
    miss = (k >= 0) ? (mask & ~mmask[set][k]) : mask;
    for (int s = 0; s < 4; s++) begin
      if (miss[s]) begin efa[nexp] = {addr[15:6], 2'(s), 4'h0}; nexp++; end
      if (mask[s]) edata[s*32 +: 32] = memf({addr[15:6], 2'(s), 4'h0});
    end
    req_valid = 1'b1; req_addr = addr; req_mask = mask;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (!keep) req_valid = 1'b0;
    forever begin
      if (resp_valid) break;
      if (req_ready) busy_ok = 0;
      if (fill_req_valid) begin
        if (n < 8) begin
          fa[n] = fill_req_addr; fs[n] = fill_req_set;
          fw[n] = fill_req_way; fsec[n] = fill_req_sector;
        end
        n++;
      end else if (n > 0 && !sent) begin
        sent = 1;
        for (int i = ((n < 8) ? n : 8) - 1; i >= 0; i--) begin
          fill_rsp_valid = 1'b1; fill_rsp_set = fs[i]; fill_rsp_way = fw[i];
          fill_rsp_sector = fsec[i]; fill_rsp_data = memf(fa[i]);
          @(negedge clk);
        end
        fill_rsp_valid = 1'b0;
        continue;
      end
      @(negedge clk);
    end
    chk({rq, " fill count"}, 128'(n), 128'(nexp));
    for (int i = 0; i < nexp && i < n && i < 8; i++)
      chk({rq, " R3 fill address"}, 128'(fa[i]), 128'(efa[i]));
    chk({rq, " R2 response data"}, resp_data, edata);
    if (keep) chk("R8 ready held low while busy", 128'(busy_ok), 128'(1));
    @(negedge clk);
    if (k >= 0) begin
      logic [3:0] m = mmask[set][k] | mask;
      for (int j = k; j > 0; j--) begin mtag[set][j] = mtag[set][j-1]; mmask[set][j] = mmask[set][j-1]; end
      mtag[set][0] = tag; mmask[set][0] = m;
    end else begin
      nc = (mcnt[set] < WAYS) ? mcnt[set] + 1 : WAYS;
      for (int j = nc - 1; j > 0; j--) begin mtag[set][j] = mtag[set][j-1]; mmask[set][j] = mmask[set][j-1]; end
      mtag[set][0] = tag; mmask[set][0] = mask; mcnt[set] = nc;
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R8 watchdog actual=hung expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] r = 16'hACE1;
    for (int s = 0; s < 4; s++) mcnt[s] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", 128'({req_ready, resp_valid, fill_req_valid}), 128'(3'b100));

    do_req(16'h0100, 4'b1111, 0, "R4 cold full line");
    do_req(16'h0100, 4'b1111, 0, "R4 full line repeat");

    do_req(16'h5200, 4'b0001, 0, "R5 sector 0");
    do_req(16'h5210, 4'b0010, 0, "R5 sector 1");
    do_req(16'h5220, 4'b0100, 0, "R5 sector 2");
    do_req(16'h5230, 4'b1000, 0, "R5 sector 3");
    do_req(16'h5200, 4'b1111, 0, "R5 all kept");

    do_req(16'h1080, 4'b0101, 0, "R3 partial");
    do_req(16'h1080, 4'b0111, 0, "R3 one more sector");

    do_req(16'h1040, 4'b0011, 0, "R7 fill way A");
    do_req(16'h2040, 4'b1100, 0, "R7 fill way B");
    do_req(16'h1040, 4'b0011, 0, "R7 touch A");
    do_req(16'h3040, 4'b0001, 0, "R6 evict LRU");
    do_req(16'h1040, 4'b0011, 0, "R7 survivor hits");
    do_req(16'h2040, 4'b1100, 0, "R6 evicted refetch");

    do_req(16'h77C0, 4'b0100, 1, "R8 first of pair");
    do_req(16'h77C0, 4'b0100, 0, "R8 held request");

    for (int it = 0; it < 300; it++) begin
      logic [15:0] a;
      logic [3:0]  m;
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      a = {8'h40 + {6'b0, r[1:0]}, r[3:2], 6'h0};
      m = (r[7:4] == 4'b0) ? 4'b1000 : r[7:4];
      do_req(a, m, 0, "R9 sweep");
    end

    summary();
    $finish;
  end
endmodule